// File: doc/BRIEF.md
# Configuration File Header Parser

This block reads an FPGA configuration file as a byte stream, one byte per accepted cycle, and hands on only the raw configuration payload. First it checks a fixed eleven-byte magic preamble and a 16-bit version word. Then it walks four tagged text sections and throws their bodies away. Next it reads a tagged 32-bit payload length and forwards exactly that many bytes downstream, with a last flag. Nothing is buffered. Every check is made as the byte that decides it arrives.

The upstream side is a valid/ready byte stream whose final file byte carries `in_last`. The downstream side is a valid/ready byte stream that passes straight through while the payload is being forwarded, so back-pressure reaches the source with no added latency. Three status outputs report the result. The assembled payload length appears on `pay_len`. A single-cycle `done` pulse marks a file that parsed cleanly. `err` holds a sticky error code that only a synchronous reset clears.

Top module: `cfgfile_parser`

## Requirements
- R1: The first 11 bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00. A mismatch, or `in_last` on any of these bytes, sets `err` to 1 (bad header).
- R2: Bytes 11 and 12 form a big-endian word that must be 0x0001. A wrong value, or `in_last` on byte 11, sets `err` to 2.
- R3: Four sections follow, with tags 0x61, 0x62, 0x63, 0x64 in that order. Each section is a tag byte, a big-endian 16-bit length, and that many body bytes. The parser skips the bodies and never forwards them.
- R4: A tag byte other than the one expected at its position sets `err` to 3. This includes a byte other than 0x65 after the fourth section.
- R5: `err` becomes 4 (truncated section) when `in_last` arrives after the version word is complete but before the header is finished. This covers the last version byte, any section tag, length or body byte, the 0x65 tag, and the first three payload-length bytes.
- R6: The four bytes after 0x65 are a big-endian 32-bit payload length. Once the last of them is accepted, `pay_len` holds that value.
- R7: Payload bytes appear unchanged and in order on `out_data`. `out_last` is high only on the byte whose index equals the declared length minus one.
- R8: `err` becomes 5 (length mismatch) in either of two cases. The input can end before the declared count is reached. Or the byte that completes the count, or the last length byte when the length is zero, can arrive without `in_last`.
- R9: A declared length of zero forwards no bytes. `done` is raised when the last length byte arrives with `in_last`.
- R10: `done` is a one-cycle pulse in the cycle after the final file byte is accepted. It appears only for a file with no error, and at most once until reset.
- R11: Once `err` is nonzero, it keeps its value until reset. From then on, no byte is forwarded and `in_ready` stays high.
- R12: While payload is being forwarded, `in_ready` equals `out_ready`. In every other state it is high.
- R13: After reset, `err` is 0, `done` is 0, `pay_len` is 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input file byte |
| in_last | input | 1 | Marks the final byte of the file |
| in_ready | output | 1 | Parser accepts the input byte |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |
| pay_len | output | 32 | Declared payload length |
| done | output | 1 | One-cycle pulse on a cleanly parsed file |
| err | output | 3 | Sticky error code: 0 none, 1 header, 2 version, 3 tag, 4 truncated, 5 length |

## Verification
A wrong skip counter shows up within a byte or two of the section it corrupts. The next tag is then read at the wrong offset, which gives an error code of 3 where 0 or 4 was expected, or an early start of forwarding. A wrong payload counter shows at the ports as a misplaced `out_last` or a spurious or missing length-mismatch error, at the end of the payload at the latest. The truncation sweep ends the file at every byte position, and each position has exactly one correct error code. So a wrong state-to-state boundary produces a wrong code on the very run that ends there.

// File: rtl/cfgfile_parser.sv
module cfgfile_parser (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready,
  output logic [31:0] pay_len,
  output logic        done,
  output logic [2:0]  err
);
  localparam int PRE_LEN = 11;
  localparam logic [7:0] TAG_FIRST = 8'h61;
  localparam logic [7:0] TAG_PAY   = 8'h65;
  localparam logic [2:0] E_HDR = 3'd1, E_VER = 3'd2, E_TAG = 3'd3, E_TRUNC = 3'd4, E_LEN = 3'd5;

  typedef enum logic [3:0] {
    S_PRE, S_VER, S_TAG, S_LHI, S_LLO, S_BODY, S_ETAG, S_PLEN, S_PAY, S_DONE, S_ERR
  } state_t;

  state_t      state;
  logic [3:0]  idx;
  logic [1:0]  sec;
  logic [15:0] skip_cnt;
  logic [31:0] len_sh;
  logic [31:0] pay_cnt;
  logic [2:0]  err_q;
  logic        done_q;

  function automatic logic [7:0] pre_byte(input logic [3:0] i);
    if (i == 4'd0 || i == 4'd10) return 8'h00;
    if (i == 4'd1) return 8'h09;
    return i[0] ? 8'hF0 : 8'h0F;
  endfunction

  wire in_pay = (state == S_PAY);
  wire acc    = in_valid && in_ready;
  wire [31:0] len_next = {len_sh[23:0], in_data};
  wire [15:0] skip_next = {skip_cnt[15:8], in_data};

  assign in_ready  = in_pay ? out_ready : 1'b1;
  assign out_valid = in_pay && in_valid;
  assign out_data  = in_data;
  assign out_last  = in_pay && (pay_cnt == 32'd1);
  assign pay_len   = len_sh;
  assign done      = done_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_PRE;
      idx      <= '0;
      sec      <= '0;
      skip_cnt <= '0;
      len_sh   <= '0;
      pay_cnt  <= '0;
      err_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (acc) begin
        case (state)
          S_PRE: begin
            if (in_data != pre_byte(idx) || in_last) begin
              err_q <= E_HDR;
              state <= S_ERR;
            end else if (idx == 4'(PRE_LEN - 1)) begin
              idx   <= '0;
              state <= S_VER;
            end else begin
              idx <= idx + 4'd1;
            end
          end
          S_VER: begin
            if (in_data != ((idx == 4'd0) ? 8'h00 : 8'h01)) begin
              err_q <= E_VER;
              state <= S_ERR;
            end else if (in_last) begin
              err_q <= (idx == 4'd0) ? E_VER : E_TRUNC;
              state <= S_ERR;
            end else if (idx == 4'd1) begin
              idx   <= '0;
              sec   <= '0;
              state <= S_TAG;
            end else begin
              idx <= 4'd1;
            end
          end
          S_TAG: begin
            if (in_data != TAG_FIRST + 8'(sec)) begin
              err_q <= E_TAG;
              state <= S_ERR;
            end else if (in_last) begin
              err_q <= E_TRUNC;
              state <= S_ERR;
            end else begin
              state <= S_LHI;
            end
          end
          S_LHI: begin
            skip_cnt[15:8] <= in_data;
            if (in_last) begin
              err_q <= E_TRUNC;
              state <= S_ERR;
            end else begin
              state <= S_LLO;
            end
          end
          S_LLO: begin
            skip_cnt <= skip_next;
            if (in_last) begin
              err_q <= E_TRUNC;
              state <= S_ERR;
            end else if (skip_next != 16'd0) begin
              state <= S_BODY;
            end else if (sec == 2'd3) begin
              state <= S_ETAG;
            end else begin
              sec   <= sec + 2'd1;
              state <= S_TAG;
            end
          end
          S_BODY: begin
            skip_cnt <= skip_cnt - 16'd1;
            if (in_last) begin
              err_q <= E_TRUNC;
              state <= S_ERR;
            end else if (skip_cnt == 16'd1) begin
              if (sec == 2'd3) begin
                state <= S_ETAG;
              end else begin
                sec   <= sec + 2'd1;
                state <= S_TAG;
              end
            end
          end
          S_ETAG: begin
            if (in_data != TAG_PAY) begin
              err_q <= E_TAG;
              state <= S_ERR;
            end else if (in_last) begin
              err_q <= E_TRUNC;
              state <= S_ERR;
            end else begin
              idx   <= '0;
              state <= S_PLEN;
            end
          end
          S_PLEN: begin
            len_sh <= len_next;
            if (idx == 4'd3) begin
              pay_cnt <= len_next;
              if (len_next == 32'd0) begin
                if (in_last) begin
                  done_q <= 1'b1;
                  state  <= S_DONE;
                end else begin
                  err_q <= E_LEN;
                  state <= S_ERR;
                end
              end else if (in_last) begin
                err_q <= E_LEN;
                state <= S_ERR;
              end else begin
                state <= S_PAY;
              end
            end else if (in_last) begin
              err_q <= E_TRUNC;
              state <= S_ERR;
            end else begin
              idx <= idx + 4'd1;
            end
          end
          S_PAY: begin
            pay_cnt <= pay_cnt - 32'd1;
            if (pay_cnt == 32'd1) begin
              if (in_last) begin
                done_q <= 1'b1;
                state  <= S_DONE;
              end else begin
                err_q <= E_LEN;
                state <= S_ERR;
              end
            end else if (in_last) begin
              err_q <= E_LEN;
              state <= S_ERR;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfgfile_parser_chk.sv
module cfgfile_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_last,
  input logic        out_ready,
  input logic [31:0] pay_len,
  input logic        done,
  input logic [2:0]  err
);
  logic [31:0] fwd_cnt;
  always_ff @(posedge clk) begin
    if (rst) fwd_cnt <= '0;
    else if (out_valid && out_ready) fwd_cnt <= fwd_cnt + 32'd1;
  end

  AST_LAST_INDEX: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> (fwd_cnt == pay_len - 32'd1)); // R7
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |-> (fwd_cnt < pay_len)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err != 3'd0) |=> (err == $past(err))); // R11
  AST_NO_FWD_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
    (err != 3'd0) |-> !out_valid); // R11
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !out_valid) |-> in_ready); // R12
  AST_READY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (in_ready == out_ready)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    done |-> (err == 3'd0)); // R10
endmodule

bind cfgfile_parser cfgfile_parser_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
  .pay_len(pay_len), .done(done), .err(err)
);

// File: tb/cfgfile_parser_tb.sv
module cfgfile_parser_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last, done;
  logic [7:0] out_data;
  logic [31:0] pay_len;
  logic [2:0] err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgfile_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .pay_len(pay_len), .done(done), .err(err)
  );

  int nchk = 0, nerr = 0;
  logic [7:0] fb [0:1023];
  int flen, pstart, plen, seed;
  int tpos [5];
  int got_cnt, bad_cnt, last_bad, last_seen, done_cnt, sticky_bad;

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(input int i, input int s);
    return 8'(i * 37 + s * 11 + 5);
  endfunction

  task automatic build(input int s0, input int s1, input int s2, input int s3, input int L, input int sd);
    int sl [4];
    int n;
    logic [7:0] pre [11];
    pre = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h00};
    sl = '{s0, s1, s2, s3};
    for (int i = 0; i < 11; i++) fb[i] = pre[i];
    fb[11] = 8'h00; fb[12] = 8'h01;
    n = 13;
    for (int s = 0; s < 4; s++) begin
      tpos[s] = n;
      fb[n] = 8'(8'h61 + s); fb[n+1] = 8'(sl[s] >> 8); fb[n+2] = 8'(sl[s]);
      n += 3;
      for (int j = 0; j < sl[s]; j++) begin fb[n] = 8'(8'h30 + j); n++; end
    end
    tpos[4] = n;
    fb[n] = 8'h65;
    fb[n+1] = 8'(L >> 24); fb[n+2] = 8'(L >> 16); fb[n+3] = 8'(L >> 8); fb[n+4] = 8'(L);
    n += 5;
    pstart = n;
    for (int i = 0; i < L; i++) begin fb[n] = pb(i, sd); n++; end
    flen = n; plen = L; seed = sd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int cut, input int bp, input bit stick);
    int i, cyc;
    bit hs;
    do_reset();
    i = 0; cyc = 0;
    got_cnt = 0; bad_cnt = 0; last_bad = 0; last_seen = 0; done_cnt = 0; sticky_bad = 0;
    while (i <= cut) begin
      @(negedge clk);
      out_ready = (bp == 0) ? 1'b1 : ((cyc % 3) != 1);
      in_valid  = !(bp == 2 && (cyc % 4) == 2);
      in_data   = fb[i];
      in_last   = (i == cut);
      cyc++;
      #1;
      if (done) done_cnt++;
      if (out_valid && out_ready) begin
        if (out_data != pb(got_cnt, seed)) bad_cnt++;
        if (out_last) begin
          last_seen++;
          if (got_cnt != plen - 1) last_bad++;
        end
        got_cnt++;
      end
      hs = in_valid && in_ready;
      @(posedge clk);
      if (hs) i++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    #1; if (done) done_cnt++;
    if (stick) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hA5; in_last = (k == 2);
        #1;
        if (!in_ready || out_valid || done) sticky_bad++;
      end
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    end
    repeat (2) begin @(negedge clk); #1; if (done) done_cnt++; end
  endtask

  task automatic verify(input string rerr, input int e_err, input int e_cnt, input int e_last, input bit stick);
    chk(err == 3'(e_err), rerr, err, e_err);
    chk(got_cnt == e_cnt, "R3", got_cnt, e_cnt);
    chk(bad_cnt == 0, "R7", bad_cnt, 0);
    chk(last_bad == 0 && last_seen == e_last, "R7", last_seen, e_last);
    chk(done_cnt == ((e_err == 0) ? 1 : 0), (plen == 0) ? "R9" : "R10", done_cnt, (e_err == 0) ? 1 : 0);
    if (e_err == 0) chk(pay_len == 32'(plen), "R6", pay_len, plen);
    if (stick) chk(sticky_bad == 0, "R11", sticky_bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nerr++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int lv [3];
    int pv [5];
    int e, c;
    lv = '{0, 1, 3};
    pv = '{0, 1, 2, 5, 17};

    do_reset();
    @(negedge clk); #1;
    chk(err == 3'd0 && done == 1'b0 && pay_len == 32'd0, "R13", err, 0);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R13", in_ready, 1);

    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int cc = 0; cc < 3; cc++)
          for (int d = 0; d < 3; d++)
            for (int li = 0; li < 5; li++) begin
              build(lv[a], lv[b], lv[cc], lv[d], pv[li], a + b + d + li);
              run(flen - 1, (a + b + cc + d + li) % 3, 1'b0);
              verify((pv[li] == 0) ? "R9" : "R12", 0, pv[li], (pv[li] > 0) ? 1 : 0, 1'b0);
            end

    build(2, 0, 1, 3, 300, 7);
    run(flen - 1, 1, 1'b0);
    verify("R6", 0, 300, 1, 1'b0);

    for (int j = 0; j < 11; j++) begin
      build(1, 1, 1, 1, 3, 2);
      fb[j] = fb[j] ^ 8'h10;
      run(flen - 1, 0, 1'b1);
      verify("R1", 1, 0, 0, 1'b1);
    end

    for (int j = 11; j < 13; j++) begin
      build(1, 1, 1, 1, 3, 2);
      fb[j] = fb[j] ^ 8'h01;
      run(flen - 1, 0, 1'b1);
      verify("R2", 2, 0, 0, 1'b1);
    end

    for (int p = 0; p < 5; p++) begin
      build(1, 2, 0, 1, 3, 4);
      fb[tpos[p]] = fb[tpos[p]] + 8'h01;
      run(flen - 1, 0, 1'b1);
      verify("R4", 3, 0, 0, 1'b1);
    end

    build(2, 0, 1, 3, 4, 9);
    for (int k = 0; k < flen - 1; k++) begin
      if (k < 11) e = 1;
      else if (k == 11) e = 2;
      else if (k <= pstart - 2) e = 4;
      else e = 5;
      c = (k >= pstart) ? (k - pstart + 1) : 0;
      run(k, k % 3, 1'b1);
      verify((e == 1) ? "R1" : (e == 2) ? "R2" : (e == 4) ? "R5" : "R8", e, c, 0, 1'b1);
    end

    for (int li = 0; li < 5; li++) begin
      build(1, 0, 2, 1, pv[li], 3);
      fb[flen] = 8'h5A;
      run(flen, 1, 1'b1);
      verify("R8", 5, pv[li], (pv[li] > 0) ? 1 : 0, 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule